// File: doc/BRIEF.md
# Polyphase Decimating Down-Converter

This block takes a stream of real, signed samples from an intermediate-frequency source and turns it into complex baseband samples at exactly one eighth of the accepted input rate. A numerically controlled oscillator supplies cosine and sine values for each accepted sample. The mixer multiplies the sample by those values. A 64-tap low-pass filter then folds the divide-by-8 into its polyphase structure, so each output is built from eight partial dot products as the samples of one block arrive.

The whole datapath runs from one clock. A valid strobe qualifies each input. Idle cycles are allowed anywhere and change nothing. The oscillator step is an input port, so the mixing frequency can be retuned. The coefficient set is chosen at elaboration from a small table that the block computes itself. Each output carries full-precision accumulation, is scaled by a fixed gain, and is then rounded and saturated.

Top module: `pp_ddc`

## Requirements
- R1: A 16-bit phase accumulator starts at 0 after reset. Each accepted sample uses the current phase, and the accumulator then advances by `phase_inc` (mod 2^16). Phase bits [15:14] give the quadrant qd and bits [13:8] give the index i, with Q = 64. The quarter table is S[t] = floor(32767·16·u / (5·128² − 4·u)) with u = t·(128 − t), for t = 0..64. By quadrant, (cos, sin) is: qd=0 gives (S[Q−i], S[i]); qd=1 gives (−S[i], S[Q−i]); qd=2 gives (−S[Q−i], −S[i]); qd=3 gives (S[i], −S[Q−i]).
- R2: Each accepted sample x is mixed at full precision to mI = x·cos and mQ = −x·sin. A zero input gives zero mixed values.
- R3: `out_valid` is high for exactly one clock per 8 accepted samples. The pulse starts at the second rising edge after the edge that accepts the 8th sample of a block. No output appears before the 8th sample after reset.
- R4: Output r (r = 0, 1, …, counted from reset) is the filtered value Σ h[n]·m[8r+7−n] for n = 0..63. Here m[j] is the mixed value of the j-th accepted sample, and samples before reset count as zero. This holds separately for I and Q.
- R5: The default coefficient set (`COEF_SET`=1) is triangular: h[n] = 31·min(n+1, 64−n). `COEF_SET`=0 selects a flat set, h[n] = 512.
- R6: Each sum s is scaled to y = floor((s + 2^24) / 2^25). The result is then clamped to [−32768, 32767].
- R7: A cycle with `in_valid` low changes no state, whatever value `in_sample` holds. Gaps of idle cycles between samples leave every output value unchanged.
- R8: The reset is synchronous and active high. It clears the phase accumulator, the branch delay lines, the block counter and the pipeline, so `out_valid`, `out_i` and `out_q` read 0. Any partially received block is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole datapath |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_sample` as an accepted sample this cycle |
| in_sample | input | 12 | Signed real input sample |
| phase_inc | input | 16 | Oscillator phase step applied per accepted sample |
| out_valid | output | 1 | One-cycle strobe for a decimated output |
| out_i | output | 16 | Signed in-phase baseband output |
| out_q | output | 16 | Signed quadrature baseband output |

## Verification
The filter is first driven with a constant input at zero oscillator step. The filling delay lines then trace out the running sum of the triangular coefficients, which exposes any misplaced or swapped tap. A quarter-rate step and a half-rate step make the oscillator hit only the exact table ends, so sign errors between the I and Q rails, and quadrant mapping errors, separate cleanly from table rounding. A 45-degree step with a pseudo-random input exercises mid-table entries. A ramp with idle gaps, and garbage on the data bus during the gaps, shows that bubbles neither shift the phase nor enter the delay lines. Full-scale positive and negative constants drive both saturation limits. Directed runs check the output timing, check that nothing is emitted before a block completes, and check that a reset in mid-block discards the partial block.

// File: rtl/ddc_pkg.sv
`timescale 1ns/1ps
package ddc_pkg;

   typedef enum logic [1:0] {
      QUAD_0 = 2'd0,
      QUAD_1 = 2'd1,
      QUAD_2 = 2'd2,
      QUAD_3 = 2'd3
   } quad_e;

   // Rational approximation of a quarter sine wave, t in 0..q, scaled to amp.
   function automatic longint sine_entry(input int t, input int q, input int amp);
      longint p;
      longint u;
      p = 2 * longint'(q);
      u = longint'(t) * (p - longint'(t));
      return (longint'(amp) * 16 * u) / (5 * p * p - 4 * u);
   endfunction

   // Coefficient generator: set 0 is flat, set 1 is a triangular taper.
   function automatic longint coef_entry(input int set, input int n, input int taps, input int cw);
      longint full;
      longint half;
      longint w;
      longint k;
      full = longint'(1) << (cw - 1);
      if (set == 0) begin
         return full / longint'(taps);
      end
      half = longint'(taps) / 2;
      w = (n < taps / 2) ? longint'(n + 1) : longint'(taps - n);
      k = (full - 1) / (half * (half + 1));
      return k * w;
   endfunction

endpackage

// File: rtl/ddc_nco.sv
`timescale 1ns/1ps
module ddc_nco
   import ddc_pkg::*;
#(
   parameter int PHASE_W = 16,
   parameter int LUT_AW  = 6,
   parameter int LO_W    = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     step,
   input  logic [PHASE_W-1:0]       phase_inc,
   output logic signed [LO_W-1:0]   cos_o,
   output logic signed [LO_W-1:0]   sin_o
);

   localparam int QN  = 1 << LUT_AW;
   localparam int AMP = (1 << (LO_W - 1)) - 1;
   localparam logic [LUT_AW:0] QV = (LUT_AW + 1)'(QN);

   logic [PHASE_W-1:0]      acc;
   logic signed [LO_W-1:0]  tab [QN+1];
   quad_e                   quad;
   logic [LUT_AW:0]         idx_e;
   logic [LUT_AW:0]         idx_c;
   logic signed [LO_W-1:0]  va;
   logic signed [LO_W-1:0]  vb;

   for (genvar t = 0; t <= QN; t++) begin : g_tab
      assign tab[t] = LO_W'(sine_entry(t, QN, AMP));
   end

   assign quad  = quad_e'(acc[PHASE_W-1 -: 2]);
   assign idx_e = {1'b0, acc[PHASE_W-3 -: LUT_AW]};
   assign idx_c = QV - idx_e;
   assign va    = tab[idx_e];
   assign vb    = tab[idx_c];

   always_comb begin
      unique case (quad)
         QUAD_0: begin cos_o = vb;  sin_o = va;  end
         QUAD_1: begin cos_o = -va; sin_o = vb;  end
         QUAD_2: begin cos_o = -vb; sin_o = -va; end
         default: begin cos_o = va; sin_o = -vb; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc <= '0;
      end else if (step) begin
         acc <= acc + phase_inc;
      end
   end

   // R7: the oscillator phase only moves on an accepted sample.
   p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(acc));

endmodule

// File: rtl/ddc_mixer.sv
`timescale 1ns/1ps
module ddc_mixer #(
   parameter int IN_W = 12,
   parameter int LO_W = 16,
   parameter int MW   = IN_W + LO_W
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_sample,
   input  logic signed [LO_W-1:0]  cos_i,
   input  logic signed [LO_W-1:0]  sin_i,
   output logic                    mix_v,
   output logic signed [MW-1:0]    mix_i,
   output logic signed [MW-1:0]    mix_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         mix_v <= 1'b0;
         mix_i <= '0;
         mix_q <= '0;
      end else begin
         mix_v <= in_valid;
         if (in_valid) begin
            mix_i <= MW'(in_sample) * MW'(cos_i);
            mix_q <= -(MW'(in_sample) * MW'(sin_i));
         end
      end
   end

   // R2: a zero sample leaves nothing on either rail.
   p_zero_mix_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_sample == '0) |=> (mix_v && mix_i == '0 && mix_q == '0));

endmodule

// File: rtl/ddc_polyfir.sv
`timescale 1ns/1ps
module ddc_polyfir
   import ddc_pkg::*;
#(
   parameter int MW       = 28,
   parameter int COEF_W   = 16,
   parameter int DECIM    = 8,
   parameter int TPB      = 8,
   parameter int COEF_SET = 1,
   parameter int ACC_W    = MW + COEF_W + 6
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     mix_v,
   input  logic signed [MW-1:0]     mix_i,
   input  logic signed [MW-1:0]     mix_q,
   output logic                     fin_v,
   output logic signed [ACC_W-1:0]  fin_i,
   output logic signed [ACC_W-1:0]  fin_q
);

   localparam int TAPS = DECIM * TPB;
   localparam int CW   = $clog2(DECIM);
   localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

   logic signed [COEF_W-1:0] h_rom [TAPS];
   logic signed [MW-1:0]     bl_i  [DECIM][TPB];
   logic signed [MW-1:0]     bl_q  [DECIM][TPB];
   logic signed [MW-1:0]     sel_i [TPB];
   logic signed [MW-1:0]     sel_q [TPB];
   logic signed [COEF_W-1:0] coef  [TPB];
   logic signed [ACC_W-1:0]  dot_i;
   logic signed [ACC_W-1:0]  dot_q;
   logic signed [ACC_W-1:0]  acc_i;
   logic signed [ACC_W-1:0]  acc_q;
   logic [CW-1:0]            cnt;
   logic [CW-1:0]            br;
   logic                     last;

   // Coefficient variant chosen at elaboration.
   for (genvar n = 0; n < TAPS; n++) begin : g_coef
      if (COEF_SET == 0) begin : g_flat
         assign h_rom[n] = COEF_W'(coef_entry(0, n, TAPS, COEF_W));
      end else begin : g_tri
         assign h_rom[n] = COEF_W'(coef_entry(1, n, TAPS, COEF_W));
      end
   end

   // Samples of a block arrive for branches DECIM-1 down to 0.
   assign br   = LAST - cnt;
   assign last = (cnt == LAST);

   // One shared tap bank serves whichever branch is active; I and Q use the same coefficient fetch.
   always_comb begin
      for (int k = 0; k < TPB; k++) begin
         coef[k] = h_rom[k * DECIM + int'(br)];
         if (k == 0) begin
            sel_i[k] = mix_i;
            sel_q[k] = mix_q;
         end else begin
            sel_i[k] = bl_i[br][k-1];
            sel_q[k] = bl_q[br][k-1];
         end
      end
      dot_i = '0;
      dot_q = '0;
      for (int k = 0; k < TPB; k++) begin
         dot_i = dot_i + ACC_W'(sel_i[k]) * ACC_W'(coef[k]);
         dot_q = dot_q + ACC_W'(sel_q[k]) * ACC_W'(coef[k]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         acc_i <= '0;
         acc_q <= '0;
         fin_v <= 1'b0;
         fin_i <= '0;
         fin_q <= '0;
         for (int b = 0; b < DECIM; b++) begin
            for (int k = 0; k < TPB; k++) begin
               bl_i[b][k] <= '0;
               bl_q[b][k] <= '0;
            end
         end
      end else begin
         fin_v <= 1'b0;
         if (mix_v) begin
            bl_i[br][0] <= mix_i;
            bl_q[br][0] <= mix_q;
            for (int k = 1; k < TPB; k++) begin
               bl_i[br][k] <= bl_i[br][k-1];
               bl_q[br][k] <= bl_q[br][k-1];
            end
            cnt <= last ? '0 : cnt + 1'b1;
            if (last) begin
               fin_i <= acc_i + dot_i;
               fin_q <= acc_q + dot_q;
               fin_v <= 1'b1;
            end else if (cnt == '0) begin
               acc_i <= dot_i;
               acc_q <= dot_q;
            end else begin
               acc_i <= acc_i + dot_i;
               acc_q <= acc_q + dot_q;
            end
         end
      end
   end

   // R3: a finished sum is always triggered by a mixed sample one cycle earlier.
   p_fin_follows_sample_r3: assert property (@(posedge clk) disable iff (rst)
      fin_v |-> $past(mix_v));

   // R7: without a mixed sample the block position stays where it is.
   p_idle_count_r7: assert property (@(posedge clk) disable iff (rst)
      !mix_v |=> $stable(cnt));

endmodule

// File: rtl/ddc_round_sat.sv
`timescale 1ns/1ps
module ddc_round_sat #(
   parameter int ACC_W = 50,
   parameter int SHIFT = 25,
   parameter int OUT_W = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     fin_v,
   input  logic signed [ACC_W-1:0]  fin_i,
   input  logic signed [ACC_W-1:0]  fin_q,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  out_i,
   output logic signed [OUT_W-1:0]  out_q
);

   localparam logic signed [ACC_W:0] BIAS = (ACC_W + 1)'(longint'(1) <<< (SHIFT - 1));
   localparam logic signed [ACC_W:0] MAXV = (ACC_W + 1)'((longint'(1) <<< (OUT_W - 1)) - 1);
   localparam logic signed [ACC_W:0] MINV = -MAXV - 1;

   function automatic logic signed [OUT_W-1:0] rnd_sat(input logic signed [ACC_W-1:0] a);
      logic signed [ACC_W:0] b;
      b = $signed({a[ACC_W-1], a}) + BIAS;
      b = b >>> SHIFT;
      if (b > MAXV) begin
         return MAXV[OUT_W-1:0];
      end else if (b < MINV) begin
         return MINV[OUT_W-1:0];
      end
      return b[OUT_W-1:0];
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= fin_v;
         if (fin_v) begin
            out_i <= rnd_sat(fin_i);
            out_q <= rnd_sat(fin_q);
         end
      end
   end

   // R6: scaling and clamping never flip the sign of a sum.
   p_sign_pos_r6: assert property (@(posedge clk) disable iff (rst)
      (fin_v && !fin_i[ACC_W-1]) |=> !out_i[OUT_W-1]);
   p_sign_neg_r6: assert property (@(posedge clk) disable iff (rst)
      (fin_v && fin_q[ACC_W-1]) |=> (out_q[OUT_W-1] || out_q == '0));

endmodule

// File: rtl/pp_ddc.sv
`timescale 1ns/1ps
module pp_ddc #(
   parameter int IN_W      = 12,
   parameter int OUT_W     = 16,
   parameter int LO_W      = 16,
   parameter int COEF_W    = 16,
   parameter int PHASE_W   = 16,
   parameter int LUT_AW    = 6,
   parameter int DECIM     = 8,
   parameter int TPB       = 8,
   parameter int COEF_SET  = 1,
   parameter int GAIN_LOG2 = 5
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [IN_W-1:0]   in_sample,
   input  logic [PHASE_W-1:0]       phase_inc,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  out_i,
   output logic signed [OUT_W-1:0]  out_q
);

   localparam int MW    = IN_W + LO_W;
   localparam int TAPS  = DECIM * TPB;
   localparam int ACC_W = MW + COEF_W + $clog2(TAPS);
   localparam int SHIFT = (LO_W - 1) + (COEF_W - 1) - GAIN_LOG2;

   // Elaboration-time parameter checks.
   if (DECIM < 2 || (DECIM & (DECIM - 1)) != 0) begin : g_bad_decim
      $error("DECIM must be a power of two of at least 2");
   end
   if (TPB < 1) begin : g_bad_tpb
      $error("TPB must be at least 1");
   end
   if (PHASE_W < LUT_AW + 2) begin : g_bad_phase
      $error("PHASE_W must cover quadrant and table index bits");
   end
   if (SHIFT < 1) begin : g_bad_shift
      $error("GAIN_LOG2 leaves no rounding shift");
   end
   if (COEF_SET != 0 && COEF_SET != 1) begin : g_bad_set
      $error("COEF_SET must be 0 or 1");
   end
   if (ACC_W > 63) begin : g_bad_acc
      $error("accumulator wider than the rounding stage supports");
   end

   logic signed [LO_W-1:0]  lo_cos;
   logic signed [LO_W-1:0]  lo_sin;
   logic                    mix_v;
   logic signed [MW-1:0]    mix_i;
   logic signed [MW-1:0]    mix_q;
   logic                    fin_v;
   logic signed [ACC_W-1:0] fin_i;
   logic signed [ACC_W-1:0] fin_q;

   ddc_nco #(
      .PHASE_W (PHASE_W),
      .LUT_AW  (LUT_AW),
      .LO_W    (LO_W)
   ) u_nco (
      .clk       (clk),
      .rst       (rst),
      .step      (in_valid),
      .phase_inc (phase_inc),
      .cos_o     (lo_cos),
      .sin_o     (lo_sin)
   );

   ddc_mixer #(
      .IN_W (IN_W),
      .LO_W (LO_W),
      .MW   (MW)
   ) u_mix (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .cos_i     (lo_cos),
      .sin_i     (lo_sin),
      .mix_v     (mix_v),
      .mix_i     (mix_i),
      .mix_q     (mix_q)
   );

   ddc_polyfir #(
      .MW       (MW),
      .COEF_W   (COEF_W),
      .DECIM    (DECIM),
      .TPB      (TPB),
      .COEF_SET (COEF_SET),
      .ACC_W    (ACC_W)
   ) u_fir (
      .clk   (clk),
      .rst   (rst),
      .mix_v (mix_v),
      .mix_i (mix_i),
      .mix_q (mix_q),
      .fin_v (fin_v),
      .fin_i (fin_i),
      .fin_q (fin_q)
   );

   ddc_round_sat #(
      .ACC_W (ACC_W),
      .SHIFT (SHIFT),
      .OUT_W (OUT_W)
   ) u_rs (
      .clk       (clk),
      .rst       (rst),
      .fin_v     (fin_v),
      .fin_i     (fin_i),
      .fin_q     (fin_q),
      .out_valid (out_valid),
      .out_i     (out_i),
      .out_q     (out_q)
   );

   // R8: the cycle after a reset edge shows no output strobe.
   p_reset_quiet_r8: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && out_i == '0 && out_q == '0));

   // R3: strobes are isolated single-cycle pulses.
   p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

endmodule

// File: tb/pp_ddc_tb.sv
`timescale 1ns/1ps
module pp_ddc_tb;

   logic               clk = 1'b0;
   logic               rst;
   logic               in_valid;
   logic signed [11:0] in_sample;
   logic [15:0]        phase_inc;
   logic               out_valid;
   logic signed [15:0] out_i;
   logic signed [15:0] out_q;

   always #2 clk = ~clk;

   pp_ddc u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .phase_inc (phase_inc),
      .out_valid (out_valid),
      .out_i     (out_i),
      .out_q     (out_q)
   );

   int     tests = 0;
   int     fails = 0;
   int     cyc   = 0;
   bit     done  = 1'b0;
   string  tag   = "R8";
   int     xs    [512];
   int     phs   [512];
   int     edg   [512];
   int     n_in  = 0;
   int     n_out = 0;
   int     ph_m  = 0;

   // stimulus: phase step[35:20], pattern[19:16], amplitude[15:4], idle gap[3:0]
   localparam logic [35:0] VEC [7] = '{
      {16'd0,     4'd0, 12'd1000, 4'd0},
      {16'd16384, 4'd0, 12'd700,  4'd0},
      {16'd8192,  4'd3, 12'd0,    4'd0},
      {16'd4000,  4'd2, 12'd0,    4'd2},
      {16'd0,     4'd0, 12'd2047, 4'd0},
      {16'd0,     4'd0, 12'h800,  4'd0},
      {16'd32768, 4'd1, 12'd1500, 4'd1}
   };
   localparam string VTAG [7] = '{"R5", "R2", "R1", "R7", "R6", "R6", "R4"};

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string t, input string what, input longint got, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", t, what, got, exp);
      end
   endtask

   function automatic longint qsin(input int t);
      longint u;
      u = longint'(t) * (128 - t);
      return (longint'(32767) * 16 * u) / (81920 - 4 * u);
   endfunction

   function automatic longint lo_val(input int ph, input bit want_sin);
      int qd;
      int i;
      longint a;
      longint b;
      qd = (ph >> 14) & 3;
      i  = (ph >> 8) & 63;
      a  = qsin(i);
      b  = qsin(64 - i);
      case (qd)
         0: return want_sin ? a : b;
         1: return want_sin ? b : -a;
         2: return want_sin ? -a : -b;
         default: return want_sin ? -b : a;
      endcase
   endfunction

   function automatic longint hco(input int n);
      return 31 * ((n < 32) ? (n + 1) : (64 - n));
   endfunction

   function automatic longint expect_out(input int r, input bit qrail);
      longint s;
      longint m;
      longint y;
      s = 0;
      for (int n = 0; n < 64; n++) begin
         int j;
         j = 8 * r + 7 - n;
         if (j >= 0) begin
            m = qrail ? -(longint'(xs[j]) * lo_val(phs[j], 1'b1))
                      : longint'(xs[j]) * lo_val(phs[j], 1'b0);
            s += hco(n) * m;
         end
      end
      y = (s + (longint'(1) <<< 24)) >>> 25;
      if (y > 32767) y = 32767;
      if (y < -32768) y = -32768;
      return y;
   endfunction

   function automatic int pat_val(input int pat, input int amp, input int k);
      case (pat)
         0: return amp;
         1: return (k % 2 == 1) ? -amp : amp;
         2: return ((k * 97) % 4096) - 2048;
         default: return ((k * 2731 + 1237) % 4096) - 2048;
      endcase
   endfunction

   // Output monitor, sampled away from the active edge.
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (8 * n_out + 7 < n_in) begin
            chk(out_i == 16'(expect_out(n_out, 1'b0)), tag, $sformatf("out %0d I", n_out),
                out_i, expect_out(n_out, 1'b0));
            chk(out_q == 16'(expect_out(n_out, 1'b1)), tag, $sformatf("out %0d Q", n_out),
                out_q, expect_out(n_out, 1'b1));
            chk(cyc == edg[8 * n_out + 7] + 2, "R3", $sformatf("out %0d edge", n_out),
                cyc, edg[8 * n_out + 7] + 2);
         end else begin
            chk(1'b0, "R3", "strobe before block complete", n_in, 8 * n_out + 8);
         end
         n_out++;
      end
   end

   task automatic send(input int x);
      in_valid  = 1'b1;
      in_sample = 12'(x);
      @(negedge clk);
      xs[n_in]  = x;
      phs[n_in] = ph_m;
      edg[n_in] = cyc;
      n_in++;
      ph_m      = (ph_m + int'(phase_inc)) % 65536;
      in_valid  = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         in_valid  = 1'b0;
         in_sample = 12'($urandom);
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      rst      = 1'b1;
      @(negedge clk);
      @(negedge clk);
      n_in  = 0;
      n_out = 0;
      ph_m  = 0;
      rst   = 1'b0;
   endtask

   initial begin
      in_valid  = 1'b0;
      in_sample = '0;
      phase_inc = '0;
      rst       = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8: state after reset
      chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
      chk(out_i == 0 && out_q == 0, "R8", "outputs after reset", out_i, 0);

      // Table walk: each entry is six blocks of eight samples.
      for (int v = 0; v < 7; v++) begin
         int pinc;
         int pat;
         int amp;
         int gap;
         pinc = int'(VEC[v][35:20]);
         pat  = int'(VEC[v][19:16]);
         amp  = int'($signed(VEC[v][15:4]));
         gap  = int'(VEC[v][3:0]);
         do_reset();
         tag = VTAG[v];
         phase_inc = 16'(pinc);
         for (int k = 0; k < 48; k++) begin
            send(pat_val(pat, amp, k));
            if (gap > 0) idle(gap);
         end
         idle(6);
         chk(n_out == 6, "R3", $sformatf("output count, vector %0d", v), n_out, 6);
      end

      // R3: no strobe before the eighth sample, then exactly one.
      do_reset();
      tag = "R3";
      phase_inc = 16'd1234;
      for (int k = 0; k < 7; k++) send(300 + k);
      idle(6);
      chk(n_out == 0, "R3", "outputs after seven samples", n_out, 0);
      send(-900);
      idle(4);
      chk(n_out == 1, "R3", "outputs after eight samples", n_out, 1);

      // R8: reset in mid-block discards the partial block.
      phase_inc = 16'd5000;
      for (int k = 0; k < 5; k++) send(1800 - 200 * k);
      do_reset();
      tag = "R8";
      idle(8);
      chk(n_out == 0, "R8", "no strobe from discarded block", n_out, 0);
      phase_inc = 16'd5000;
      for (int k = 0; k < 16; k++) send(pat_val(3, 0, k + 40));
      idle(5);
      chk(n_out == 2, "R8", "outputs after restart", n_out, 2);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #600000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R3 watchdog: actual %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule